// File: doc/BRIEF.md
# Eight-Line Prioritized Interrupt Controller

This block collects eight interrupt lines and hands the CPU core a single request with the number of the line to serve. It also gives the matching entry address in a vector table. The lines are: a software restart, a periodic tick from a built-in counter, UART transmit-done and receive-done, rising edges on two external pins, arithmetic overflow, and a processing fault. The external pins are synchronized before their edges are detected. Each table entry is an eight-instruction slot, so line n enters at address n*8 and the table spans 0x0000 to 0x003F. Line 0 sends the core back to address 0x0000 and leaves memory untouched.

Software sees two registers on a small write port. The enable register is selected with `cfg_sel`=0. The invoke register is selected with `cfg_sel`=1 and is write-only. Setting a bit of the invoke register raises that line as if its own event had occurred. Lines 0 and 7 are always enabled. A line with its enable bit clear drops its events. A pending flag stays set until the core acknowledges that vector.

The core reports its global interrupt enable, an acknowledge and an end-of-service strobe. While the global enable is off, or while a vector is being served, only lines 0 and 7 get through.

Top module: `irq_hub_top`

## Requirements
- R1: After synchronous reset, `irq_req` is 0 and `en_rdata` reads 8'h81.
- R2: A write with `cfg_sel`=0 stores bits 6..1 of the enable register. Bits 0 and 7 always read as 1, and writes to them are ignored.
- R3: A write with `cfg_sel`=1 raises each line whose data bit is 1, as do the pulses `tx_done` (line 2), `rx_done` (line 3), `ovf_evt` (line 6) and `fault_evt` (line 7). An enabled, deliverable line shows on `irq_req`/`irq_vec` after the clock edge that sampled the event.
- R4: When several deliverable lines are pending, `irq_vec` names the lowest-numbered one.
- R5: An acknowledge (`core_ack` while `irq_req` is 1) clears the pending flag of the presented vector at that edge.
- R6: An event on a line whose enable bit is 0 is dropped, and enabling the line later produces no request.
- R7: When `core_gie` is 0 or a vector is in service, lines 1 to 6 are not delivered, but lines 0 and 7 still are.
- R8: `core_iret` ends service, after which a held-back pending line is delivered at the next edge.
- R9: The tick line is raised once every `TICK_CYCLES` clock cycles (256000 by default).
- R10: `ext_pin[0]` and `ext_pin[1]` raise lines 4 and 5 on a rising edge, seen through a `SYNC_STAGES`-deep synchronizer. A steady high level or a falling edge raises nothing.
- R11: `irq_addr` equals `irq_vec` times 8, which is the slot size of the vector table.
- R12: Acknowledging vector 0 leaves the controller out of service, so pending lower-priority lines are delivered without a `core_iret`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the invoke register |
| cfg_wdata | input | 8 | Register write data, one bit per line |
| en_rdata | output | 8 | Effective enable mask, with bits 0 and 7 forced to 1 |
| tx_done | input | 1 | UART transmit-complete pulse (line 2) |
| rx_done | input | 1 | UART receive-complete pulse (line 3) |
| ovf_evt | input | 1 | Arithmetic overflow pulse (line 6) |
| fault_evt | input | 1 | Processing fault pulse (line 7) |
| ext_pin | input | 2 | Asynchronous external pins (lines 4 and 5) |
| core_gie | input | 1 | Core global interrupt enable |
| core_ack | input | 1 | Core takes the presented vector |
| core_iret | input | 1 | Core leaves the interrupt service routine |
| irq_req | output | 1 | A vector is presented |
| irq_vec | output | 3 | Number of the presented line |
| irq_addr | output | ADDR_W | Vector table entry address |

## Verification
The hardest state to reach from the ports is a vector in service with a lower-priority line pending underneath it and a fault or restart arriving on top. In that state the always-on lines must still get through while the ordinary line waits. The bench builds this state step by step. It invokes one line and acknowledges it. It then invokes a second line and checks that the line stays hidden. It then invokes line 7 or line 0 and acknowledges it. The bench then checks whether the hidden line shows up only after `core_iret`, or, in the restart case, at once.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NUM_IRQ = 8;
  localparam int VEC_W   = $clog2(NUM_IRQ);
  // lines that cannot be masked and pass every gate
  localparam logic [NUM_IRQ-1:0] FIXED_EN = 8'h81;

  typedef enum logic [VEC_W-1:0] {
    IRQ_RESTART = 3'd0,
    IRQ_TICK    = 3'd1,
    IRQ_TXDONE  = 3'd2,
    IRQ_RXDONE  = 3'd3,
    IRQ_EXT0    = 3'd4,
    IRQ_EXT1    = 3'd5,
    IRQ_OVF     = 3'd6,
    IRQ_FAULT   = 3'd7
  } irq_id_e;

  function automatic logic [VEC_W-1:0] lowest_set(input logic [NUM_IRQ-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (v[i]) r = VEC_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int TICK_CYCLES = 256000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (cnt_q == LAST);
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R9: a tick is a single-cycle pulse
  p_tick_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] sync_q [STAGES];
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= '0;
    else     sync_q[0] <= pin;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= '0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // R10: an edge pulse never lasts two cycles
  p_rise_single_r10: assert property (@(posedge clk) disable iff (rst)
    rise[0] |=> !rise[0]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_hub_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] evt,
  input  logic [NUM_IRQ-1:0] en,
  input  logic               gie,
  input  logic               ack,
  input  logic               iret,
  output logic               req_q,
  output logic [VEC_W-1:0]   vec_q
);
  logic [NUM_IRQ-1:0] pend_q, pend_d, clr, elig, en_last_q;
  logic               svc_q, svc_d, take, open_gate;

  always_comb begin
    take   = ack & req_q;
    clr    = take ? (NUM_IRQ'(1) << vec_q) : '0;
    // an event in the same cycle as the clear of its line wins
    pend_d = (pend_q & ~clr) | (evt & en);
    svc_d  = svc_q;
    if (iret) svc_d = 1'b0;
    if (take) svc_d = (vec_q != IRQ_RESTART);
    open_gate = gie & ~svc_d;
    elig = pend_d & en & (open_gate ? {NUM_IRQ{1'b1}} : FIXED_EN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      svc_q     <= 1'b0;
      req_q     <= 1'b0;
      vec_q     <= '0;
      en_last_q <= '0;
    end else begin
      pend_q    <= pend_d;
      svc_q     <= svc_d;
      req_q     <= |elig;
      vec_q     <= lowest_set(elig);
      en_last_q <= en;
    end
  end

  // R6: a presented vector was enabled when it was chosen
  p_vec_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    req_q |-> en_last_q[vec_q]);

  // R7: maskable lines need the global enable
  p_gie_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (req_q && vec_q != IRQ_RESTART && vec_q != IRQ_FAULT) |-> $past(gie));

  // R7: once a normal vector is taken, only lines 0 and 7 may follow
  p_service_block_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && req_q && vec_q != IRQ_RESTART) |=>
      (!req_q || vec_q == IRQ_RESTART || vec_q == IRQ_FAULT));
endmodule

// File: rtl/irq_hub_top.sv
module irq_hub_top
  import irq_hub_pkg::*;
#(
  parameter int TICK_CYCLES = 256000,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter int SLOT_LOG2   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        en_rdata,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic              ovf_evt,
  input  logic              fault_evt,
  input  logic [1:0]        ext_pin,
  input  logic              core_gie,
  input  logic              core_ack,
  input  logic              core_iret,
  output logic              irq_req,
  output logic [2:0]        irq_vec,
  output logic [ADDR_W-1:0] irq_addr
);
  logic [NUM_IRQ-1:0] en_q, en_eff, soft_evt, hw_evt;
  logic               tick;
  logic [1:0]         ext_rise;

  // enable register: only the maskable bits are stored
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (cfg_we && !cfg_sel) en_q <= cfg_wdata & ~FIXED_EN;
  end

  assign en_eff   = en_q | FIXED_EN;
  assign en_rdata = en_eff;
  assign soft_evt = (cfg_we && cfg_sel) ? cfg_wdata : '0;

  irq_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  irq_edge_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_ext (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_pin),
    .rise (ext_rise)
  );

  always_comb begin
    hw_evt              = '0;
    hw_evt[IRQ_TICK]    = tick;
    hw_evt[IRQ_TXDONE]  = tx_done;
    hw_evt[IRQ_RXDONE]  = rx_done;
    hw_evt[IRQ_EXT0]    = ext_rise[0];
    hw_evt[IRQ_EXT1]    = ext_rise[1];
    hw_evt[IRQ_OVF]     = ovf_evt;
    hw_evt[IRQ_FAULT]   = fault_evt;
  end

  irq_arbiter u_arb (
    .clk   (clk),
    .rst   (rst),
    .evt   (hw_evt | soft_evt),
    .en    (en_eff),
    .gie   (core_gie),
    .ack   (core_ack),
    .iret  (core_iret),
    .req_q (irq_req),
    .vec_q (irq_vec)
  );

  assign irq_addr = ADDR_W'(irq_vec) << SLOT_LOG2;
endmodule

// File: tb/tb_irq_hub_top.sv
module tb_irq_hub_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] en_rdata;
  logic tx_done = 0, rx_done = 0, ovf_evt = 0, fault_evt = 0;
  logic [1:0] ext_pin = '0;
  logic core_gie = 0, core_ack = 0, core_iret = 0;
  logic irq_req;
  logic [2:0] irq_vec;
  logic [15:0] irq_addr;

  always #10 clk = ~clk;

  irq_hub_top #(.TICK_CYCLES(16)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .en_rdata(en_rdata), .tx_done(tx_done),
    .rx_done(rx_done), .ovf_evt(ovf_evt), .fault_evt(fault_evt),
    .ext_pin(ext_pin), .core_gie(core_gie), .core_ack(core_ack),
    .core_iret(core_iret), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_addr(irq_addr)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // row: {enable, invoke, gie, exp_req, exp_vec}
  localparam logic [20:0] ROWS [9] = '{
    {8'h00, 8'h01, 1'b1, 1'b1, 3'd0},
    {8'h00, 8'h80, 1'b0, 1'b1, 3'd7},
    {8'h00, 8'h02, 1'b1, 1'b0, 3'd0},
    {8'h7E, 8'h42, 1'b1, 1'b1, 3'd1},
    {8'h7E, 8'hC0, 1'b1, 1'b1, 3'd6},
    {8'h7E, 8'h30, 1'b0, 1'b0, 3'd0},
    {8'h7E, 8'hA0, 1'b0, 1'b1, 3'd7},
    {8'h20, 8'h30, 1'b1, 1'b1, 3'd5},
    {8'hFF, 8'h81, 1'b1, 1'b1, 3'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    cfg_we = 0; core_ack = 0; core_iret = 0; ext_pin = '0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic ack();
    @(negedge clk); core_ack = 1;
    @(negedge clk); core_ack = 0;
  endtask

  task automatic iret();
    @(negedge clk); core_iret = 1;
    @(negedge clk); core_iret = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int t0, t1;
    bit seen;
    // R1 reset state
    do_reset();
    check("R1 req after reset", irq_req, 0);
    check("R1 enable after reset", en_rdata, 8'h81);

    // table: R2 enable readback, R3/R4 delivery, R11 address
    for (int i = 0; i < 9; i++) begin
      logic [20:0] r;
      r = ROWS[i];
      do_reset();
      core_gie = r[4];
      wr(0, r[20:13]);
      check("R2 enable readback", en_rdata, r[20:13] | 8'h81);
      wr(1, r[12:5]);
      check("R3/R4 req", irq_req, r[3]);
      if (r[3]) begin
        check("R4 vector", irq_vec, r[2:0]);
        check("R11 address", irq_addr, {10'd0, r[2:0], 3'd0});
      end
    end

    // R5: ack clears, next line follows after service ends
    do_reset(); core_gie = 1;
    wr(0, 8'h7E); wr(1, 8'h0C);
    check("R5 first vec", irq_vec, 2);
    ack();
    check("R5 blocked in service", irq_req, 0);
    iret();
    check("R5 next vec", irq_vec, 3);
    check("R5 next req", irq_req, 1);
    ack(); iret();
    check("R5 all cleared", irq_req, 0);

    // R6: disabled event dropped
    do_reset(); core_gie = 1;
    wr(1, 8'h04);
    check("R6 disabled no req", irq_req, 0);
    wr(0, 8'h04);
    check("R6 still nothing after enabling", irq_req, 0);

    // R7/R8: service nesting
    do_reset(); core_gie = 1;
    wr(0, 8'h7E); wr(1, 8'h08);
    check("R7 vec3", irq_vec, 3);
    ack();
    wr(1, 8'h04);
    check("R7 line2 held", irq_req, 0);
    wr(1, 8'h80);
    check("R7 fault passes", irq_vec, 7);
    check("R7 fault req", irq_req, 1);
    ack();
    check("R8 still in service", irq_req, 0);
    iret();
    check("R8 held line delivered", irq_req, 1);
    check("R8 held vec", irq_vec, 2);

    // R7: gie off
    do_reset(); core_gie = 0;
    wr(0, 8'h02); wr(1, 8'h02);
    check("R7 gie off blocks", irq_req, 0);
    @(negedge clk); core_gie = 1;
    @(negedge clk);
    check("R7 gie on delivers", irq_vec, 1);

    // R12: restart ends service
    do_reset(); core_gie = 1;
    wr(0, 8'h0C); wr(1, 8'h08); ack();
    wr(1, 8'h04);
    check("R12 held", irq_req, 0);
    wr(1, 8'h01);
    check("R12 restart vec", irq_vec, 0);
    ack();
    check("R12 no iret needed", irq_vec, 2);
    check("R12 req", irq_req, 1);

    // R3: hardware sources
    do_reset(); core_gie = 0;
    @(negedge clk); fault_evt = 1; @(negedge clk); fault_evt = 0;
    check("R3 fault with gie off", irq_vec, 7);
    do_reset(); core_gie = 1; wr(0, 8'h04);
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
    check("R3 tx_done vec", irq_vec, 2);
    do_reset(); core_gie = 1; wr(0, 8'h48);
    @(negedge clk); ovf_evt = 1; rx_done = 1; @(negedge clk); ovf_evt = 0; rx_done = 0;
    check("R3/R4 rx over overflow", irq_vec, 3);

    // R9: tick period
    do_reset(); core_gie = 1; wr(0, 8'h02);
    while (!irq_req) @(negedge clk);
    t0 = cyc;
    ack(); iret();
    while (!irq_req) @(negedge clk);
    t1 = cyc;
    check("R9 tick period", t1 - t0, 16);

    // R10: external edge
    do_reset(); core_gie = 1; wr(0, 8'h10);
    @(negedge clk); ext_pin[0] = 1;
    seen = 0;
    for (int k = 0; k < 8 && !seen; k++) begin
      @(negedge clk);
      if (irq_req) seen = 1;
    end
    check("R10 rise seen", seen, 1);
    check("R10 vec", irq_vec, 4);
    ack(); iret();
    repeat (10) @(negedge clk);
    check("R10 steady high quiet", irq_req, 0);
    ext_pin[0] = 0;
    repeat (10) @(negedge clk);
    check("R10 falling quiet", irq_req, 0);

    finish_run();
  end
endmodule